// File: doc/BRIEF.md
# I2C Master Command and Receive Queue Front-End

This block sits between a register bus and the byte-level engine of an I2C master. Software writes one combined data/command register to queue transfer steps. Bit 8 of each write picks the kind of step. When bit 8 is set, the step asks the engine to read one byte. When bit 8 is clear, the step sends the byte in bits 7:0. The engine drains this command queue through a valid/ready handshake. Each byte it receives is pushed into a receive queue. Software then pops that queue by reading the same data/command register.

Two level-based conditions let software (or an interrupt controller) pace itself. The first says the command queue has drained to a programmable low-water mark. The second says the receive queue holds more than a programmable number of bytes. A master enable gates the engine. The target address may only change while the master is off. An abort input, raised by the engine when a transfer fails, discards everything in both queues. Over- and underflow events are reported as single-cycle pulses.

Top module: `i2cm_cmdq_front`

## Requirements
- R1: A write to address 0 queues a command with bit 8 of the write data as the read flag and bits 7:0 as the byte. The engine sees commands in write order on cmd_is_read/cmd_byte while cmd_valid is high, and one is consumed per cycle with cmd_ready high.
- R2: reg_rdata at address 0 shows the oldest received byte, zero-extended, and a read strobe at address 0 removes it from the receive queue.
- R3: Addresses 1 and 2 read back the command-queue and receive-queue fill counts (0 to DEPTH). Both counts are 0 after reset.
- R4: Address 3 holds the command low-water mark (reset DEPTH-1). tx_empty_lvl is high exactly while the command count is less than or equal to it.
- R5: Address 4 holds the receive mark (reset 0). rx_full_lvl is high exactly while the receive count is greater than it.
- R6: With abort high, both counts are 0 from the next cycle. Any write, read or receive in that same cycle has no effect on the queues and raises no event pulse.
- R7: A write to address 0 while the command queue holds DEPTH entries is dropped, and tx_over is high for the one following cycle.
- R8: A read strobe at address 0 with an empty receive queue returns 0 and makes rx_under high for the one following cycle.
- R9: A received byte while the receive queue holds DEPTH entries is dropped, and rx_over is high for the one following cycle.
- R10: Address 5 bit 0 is the master enable (reset 0). While it is 0, cmd_valid stays low and queued commands are kept.
- R11: Address 6 holds the 10-bit target address (reset 0), shown on target_addr. A write there takes effect only while the enable is 0.
- R12: Queue fullness is judged on the count at the start of the cycle. A write into a full command queue is dropped even when the engine takes an entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data, combinational from reg_addr |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_ready | input | 1 | Engine takes the offered command |
| cmd_is_read | output | 1 | Offered command is a read request |
| cmd_byte | output | 8 | Byte to send for a write command |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| abort | input | 1 | Transfer abort, discards both queues |
| tx_empty_lvl | output | 1 | Command count at or below its mark |
| rx_full_lvl | output | 1 | Receive count above its mark |
| tx_over | output | 1 | Pulse: command write dropped |
| rx_under | output | 1 | Pulse: read of empty receive queue |
| rx_over | output | 1 | Pulse: received byte dropped |
| target_addr | output | 10 | Programmed target address |

## Verification
The properties assume that every strobe and data input holds a known value at each rising edge after reset. They also assume that abort may coincide with any other strobe, so each overflow property excludes the abort cycle rather than relying on the stimulus to avoid it. The bench changes inputs only shortly after the falling edge. It runs a directed phase that fills, overfills, drains and aborts each queue, and then a long randomized phase in which aborts, enable toggles and mark rewrites land next to full and empty queues.

// File: rtl/i2cm_fe_pkg.sv
package i2cm_fe_pkg;

    localparam int ADDR_W = 3;
    localparam int TGT_W  = 10;
    localparam int DATA_W = TGT_W;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA   = 3'd0,
        RA_TXLVL  = 3'd1,
        RA_RXLVL  = 3'd2,
        RA_TXTHR  = 3'd3,
        RA_RXTHR  = 3'd4,
        RA_CTRL   = 3'd5,
        RA_TARGET = 3'd6,
        RA_NONE   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic       rd;
        logic [7:0] dat;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    function automatic cmd_t make_cmd(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.rd  = w[8];
        c.dat = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/i2cm_fe_fifo.sv
module i2cm_fe_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [LVL_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == LVL_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_fe_cfg.sv
module i2cm_fe_cfg
    import i2cm_fe_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [LVL_W-1:0]  tx_thr,
    output logic [LVL_W-1:0]  rx_thr,
    output logic              en,
    output logic [TGT_W-1:0]  target
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_thr <= LVL_W'(DEPTH - 1);
            rx_thr <= '0;
            en     <= 1'b0;
            target <= '0;
        end else if (wr) begin
            case (reg_addr_e'(addr))
                RA_TXTHR:  tx_thr <= wdata[LVL_W-1:0];
                RA_RXTHR:  rx_thr <= wdata[LVL_W-1:0];
                RA_CTRL:   en     <= wdata[0];
                RA_TARGET: if (!en) target <= wdata[TGT_W-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_cmdq_front.sv
module i2cm_cmdq_front
    import i2cm_fe_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_is_read,
    output logic [7:0]        cmd_byte,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              abort,
    output logic              tx_empty_lvl,
    output logic              rx_full_lvl,
    output logic              tx_over,
    output logic              rx_under,
    output logic              rx_over,
    output logic [TGT_W-1:0]  target_addr
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             data_sel;
    logic             tx_push, tx_pop, rx_push, rx_pop;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [LVL_W-1:0] tx_lvl, rx_lvl, tx_thr, rx_thr;
    logic             en;
    cmd_t             tx_head;
    logic [7:0]       rx_head;

    assign data_sel = (reg_addr == RA_DATA);
    assign tx_push  = reg_wr & data_sel & ~abort;
    assign tx_pop   = cmd_valid & cmd_ready & ~abort;
    assign rx_pop   = reg_rd & data_sel & ~abort;
    assign rx_push  = rx_valid & ~abort;

    i2cm_fe_cfg #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .tx_thr (tx_thr),
        .rx_thr (rx_thr),
        .en     (en),
        .target (target_addr)
    );

    i2cm_fe_fifo #(.W(CMD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (abort),
        .push  (tx_push),
        .din   (make_cmd(reg_wdata)),
        .pop   (tx_pop),
        .dout  (tx_head),
        .level (tx_lvl),
        .full  (tx_full),
        .empty (tx_empty)
    );

    i2cm_fe_fifo #(.W(8), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (abort),
        .push  (rx_push),
        .din   (rx_byte),
        .pop   (rx_pop),
        .dout  (rx_head),
        .level (rx_lvl),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign cmd_valid    = en & ~tx_empty;
    assign cmd_is_read  = tx_head.rd;
    assign cmd_byte     = tx_head.dat;
    assign tx_empty_lvl = (tx_lvl <= tx_thr);
    assign rx_full_lvl  = (rx_lvl > rx_thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_over  <= 1'b0;
            rx_under <= 1'b0;
            rx_over  <= 1'b0;
        end else begin
            tx_over  <= tx_push & tx_full;
            rx_under <= rx_pop & rx_empty;
            rx_over  <= rx_push & rx_full;
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_DATA:   reg_rdata = rx_empty ? '0 : DATA_W'(rx_head);
            RA_TXLVL:  reg_rdata = DATA_W'(tx_lvl);
            RA_RXLVL:  reg_rdata = DATA_W'(rx_lvl);
            RA_TXTHR:  reg_rdata = DATA_W'(tx_thr);
            RA_RXTHR:  reg_rdata = DATA_W'(rx_thr);
            RA_CTRL:   reg_rdata = DATA_W'(en);
            RA_TARGET: reg_rdata = target_addr;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cm_fe_chk.sv
module i2cm_fe_chk
    import i2cm_fe_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              abort,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              cmd_valid,
    input logic              tx_over,
    input logic              rx_under,
    input logic [TGT_W-1:0]  target_addr,
    input logic [LVL_W-1:0]  tx_lvl,
    input logic [LVL_W-1:0]  rx_lvl,
    input logic              en
);
    // R3
    lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_lvl <= LVL_W'(DEPTH)) && (rx_lvl <= LVL_W'(DEPTH)));

    // R6
    abort_flush_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (tx_lvl == '0) && (rx_lvl == '0));

    // R7
    tx_over_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_DATA && tx_lvl == LVL_W'(DEPTH) && !abort) |=> tx_over);

    // R8
    rx_under_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == RA_DATA && rx_lvl == '0 && !abort) |=> rx_under);

    // R10
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !cmd_valid);

    // R11
    target_hold_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(target_addr));
endmodule

bind i2cm_cmdq_front i2cm_fe_chk u_chk (.*);

// File: tb/i2cm_cmdq_front_test.sv
`timescale 1ns/1ps
module i2cm_cmdq_front_test;
    localparam int DEPTH = 8;
    localparam int LVLM  = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 0, reg_rd = 0, cmd_ready = 0, rx_valid = 0, abort = 0;
    logic [2:0] reg_addr = 0;
    logic [9:0] reg_wdata = 0;
    logic [7:0] rx_byte = 0;
    logic [9:0] reg_rdata, target_addr;
    logic       cmd_valid, cmd_is_read, tx_empty_lvl, rx_full_lvl;
    logic       tx_over, rx_under, rx_over;
    logic [7:0] cmd_byte;

    int checks = 0, errors = 0;

    i2cm_cmdq_front #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_read(cmd_is_read),
        .cmd_byte(cmd_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .abort(abort), .tx_empty_lvl(tx_empty_lvl), .rx_full_lvl(rx_full_lvl),
        .tx_over(tx_over), .rx_under(rx_under), .rx_over(rx_over),
        .target_addr(target_addr)
    );

    always #4 clk = ~clk;

    // reference model state
    int tq[$];
    int rq[$];
    int m_txthr = DEPTH - 1, m_rxthr = 0, m_en = 0, m_tgt = 0;
    int m_txo = 0, m_rxu = 0, m_rxo = 0;
    int txn, rxn;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            tq.delete(); rq.delete();
            m_txthr = DEPTH - 1; m_rxthr = 0; m_en = 0; m_tgt = 0;
            m_txo = 0; m_rxu = 0; m_rxo = 0;
        end else begin
            txn = tq.size(); rxn = rq.size();
            m_txo = 0; m_rxu = 0; m_rxo = 0;
            if (abort) begin
                tq.delete(); rq.delete();
            end else begin
                if (m_en != 0 && txn > 0 && cmd_ready) void'(tq.pop_front());
                if (reg_wr && reg_addr == 0) begin
                    if (txn < DEPTH) tq.push_back(int'(reg_wdata) & 511);
                    else m_txo = 1;
                end
                if (reg_rd && reg_addr == 0) begin
                    if (rxn > 0) void'(rq.pop_front());
                    else m_rxu = 1;
                end
                if (rx_valid) begin
                    if (rxn < DEPTH) rq.push_back(int'(rx_byte));
                    else m_rxo = 1;
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd3: m_txthr = int'(reg_wdata) & LVLM;
                    3'd4: m_rxthr = int'(reg_wdata) & LVLM;
                    3'd5: m_en    = int'(reg_wdata) & 1;
                    3'd6: if (m_en == 0) m_tgt = int'(reg_wdata);
                    default: ;
                endcase
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        int e;
        string tg;
        chk("R4 tx_empty_lvl", int'(tx_empty_lvl), int'(tq.size() <= m_txthr));
        chk("R5 rx_full_lvl", int'(rx_full_lvl), int'(rq.size() > m_rxthr));
        chk("R10 cmd_valid", int'(cmd_valid), int'(m_en != 0 && tq.size() > 0));
        if (m_en != 0 && tq.size() > 0) begin
            chk("R1 cmd_is_read", int'(cmd_is_read), tq[0] >> 8);
            chk("R1 cmd_byte", int'(cmd_byte), tq[0] & 255);
        end
        chk("R7 tx_over", int'(tx_over), m_txo);
        chk("R8 rx_under", int'(rx_under), m_rxu);
        chk("R9 rx_over", int'(rx_over), m_rxo);
        chk("R11 target_addr", int'(target_addr), m_tgt);
        case (reg_addr)
            3'd0: begin e = (rq.size() > 0) ? rq[0] : 0; tg = "R2 rdata"; end
            3'd1: begin e = tq.size(); tg = "R3 rdata"; end
            3'd2: begin e = rq.size(); tg = "R3 rdata"; end
            3'd3: begin e = m_txthr; tg = "R4 rdata"; end
            3'd4: begin e = m_rxthr; tg = "R5 rdata"; end
            3'd5: begin e = m_en; tg = "R10 rdata"; end
            3'd6: begin e = m_tgt; tg = "R11 rdata"; end
            default: begin e = 0; tg = "R3 rdata unused"; end
        endcase
        chk(tg, int'(reg_rdata), e);
    end

    task automatic cyc(input logic wr, input logic rd, input int addr, input int wd,
                       input logic cr, input logic rv, input int rb, input logic ab);
        @(negedge clk);
        #1;
        reg_wr = wr; reg_rd = rd; reg_addr = 3'(addr); reg_wdata = 10'(wd);
        cmd_ready = cr; rx_valid = rv; rx_byte = 8'(rb); abort = ab;
    endtask

    task automatic idle(input int n, input int addr);
        for (int i = 0; i < n; i++) cyc(0, 0, addr, 0, 0, 0, 0, 0);
    endtask

    task automatic wreg(input int addr, input int wd);
        cyc(1, 0, addr, wd, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        cyc(0, 0, 1, 0, 0, 0, 0, 0);
        rst = 1'b0;
        // reset state
        @(posedge clk); #1;
        chk("R3 reset tx level", int'(reg_rdata), 0);
        chk("R4 reset tx_empty_lvl", int'(tx_empty_lvl), 1);
        idle(2, 2);

        // target while disabled
        wreg(6, 10'h2A5);
        idle(1, 6);
        // fill command queue with mixed commands, then overfill
        for (int i = 0; i < DEPTH; i++) wreg(0, ((i % 3) == 1) ? 9'h100 : (8'h30 + i));
        wreg(0, 8'hEE);            // dropped, R7
        idle(2, 1);
        // low-water mark change
        wreg(3, 3);
        idle(1, 3);
        // enable, then target write ignored
        wreg(5, 1);
        wreg(6, 10'h011);
        idle(1, 6);
        // drain with pulsing ready
        for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0, i % 2 == 0, 0, 0, 0);
        idle(2, 1);

        // R12: full queue, engine takes one while software writes
        wreg(5, 0);
        for (int i = 0; i < DEPTH; i++) wreg(0, 8'h50 + i);
        wreg(5, 1);
        cyc(1, 0, 0, 8'h77, 1, 0, 0, 0);
        @(posedge clk); #1;
        chk("R12 drop with same-cycle pop", int'(tx_over), 1);
        for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 1, 0, 0, 0);

        // receive path: fill, overfill, marks, pop, underflow
        wreg(4, 3);
        for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 2, 0, 0, 1, 8'hA0 + i * 7, 0);
        idle(1, 4);
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0);
        idle(2, 0);
        cyc(0, 1, 0, 0, 0, 1, 8'h5C, 0);   // read of empty plus receive
        idle(1, 0);

        // abort with queued content and concurrent activity
        wreg(5, 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 8'h10 + i, 0, 1, 8'h60 + i, 0);
        cyc(1, 1, 0, 8'h99, 0, 1, 8'hFF, 1);
        cyc(0, 0, 1, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        chk("R6 tx level after abort", int'(reg_rdata), 0);
        chk("R6 no tx_over on abort", int'(tx_over), 0);
        cyc(0, 0, 2, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        chk("R6 rx level after abort", int'(reg_rdata), 0);

        // randomized mix
        for (int i = 0; i < 3000; i++) begin
            int a, w;
            a = (($urandom % 4) == 0) ? int'($urandom % 8) : 0;
            w = int'($urandom % 1024);
            if (a == 5 || a == 3 || a == 4) w = int'($urandom % 16);
            cyc(($urandom % 3) == 0, ($urandom % 3) == 0, a, w,
                ($urandom % 2) == 0, ($urandom % 2) == 0, int'($urandom % 256),
                ($urandom % 60) == 0);
        end
        idle(3, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule